// File: doc/BRIEF.md
# Precise Exception Capture Unit

This unit sits beside a five-stage in-order pipeline and turns two fault flags into a precise trap. The decode stage raises a flag when it sees an opcode it cannot decode. The execute stage raises a flag when an arithmetic result overflows. The unit serves the fault of the oldest instruction that has one. In the same cycle it asks the pipeline to clear the control values of that instruction and of every younger one. It then stores the resume address and the fault kind, and sends fetch to the trap handler.

Instructions older than the faulting one are never cleared, so they complete and retire normally. Clearing the execute stage's control values keeps an overflowing instruction from writing its destination register. Handler addressing has two modes, chosen by an input pin. In the first, every fault goes to one fixed entry point. In the second, each fault kind has its own entry, and the entries sit a fixed 0x20 bytes apart.

A small state machine controls acceptance. It has two states. ST_RUN is the state out of reset, and faults are accepted in it. ST_SQUASH lasts exactly one cycle after a trap, and fault flags are ignored in it. There are two transitions. ST_RUN goes to ST_SQUASH when a fault is accepted (TAKE). ST_SQUASH goes back to ST_RUN on the next cycle with no condition (RESUME). Without a fault, ST_RUN stays in ST_RUN.

Top module: `exc_unit`

## Requirements
- R1: After reset, `epc` is 0 and `cause` is 0. While no fault flag is set, `take`, `kill_fetch`, `kill_decode` and `kill_execute` are all 0.
- R2: In ST_RUN with `ex_ovf` high, `take`, `kill_fetch`, `kill_decode` and `kill_execute` are all 1 in the same cycle. Killing the execute stage suppresses the overflowing instruction's register write.
- R3: In ST_RUN with `id_undef` high and `ex_ovf` low, `take`, `kill_fetch` and `kill_decode` are 1 and `kill_execute` is 0, so the older instruction in execute completes.
- R4: When both flags are high in the same ST_RUN cycle, the execute-stage overflow is the one serviced: `epc` and `cause` come from it.
- R5: On the clock edge that ends a taking cycle, `epc` loads the faulting instruction's PC plus 4, modulo 2^32. That PC is `ex_pc` for an overflow and `id_pc` for an undefined opcode.
- R6: On that same edge, `cause` loads 0 for an undefined opcode and 1 for an overflow.
- R7: `epc` and `cause` change only on the edge that ends a cycle with `take` high, and hold their values on every other edge.
- R8: With `vec_mode` = 0, `redirect_pc` is 0x80000180 whenever `take` is 1.
- R9: With `vec_mode` = 1, `redirect_pc` is 0xC0000000 + 0x20 × cause code whenever `take` is 1: 0xC0000000 for an undefined opcode and 0xC0000020 for an overflow.
- R10: In the cycle after a take (ST_SQUASH), both flags are ignored. `take` and all kill outputs are 0, and `epc` and `cause` are unchanged on the following edge.
- R11: The unit returns to ST_RUN one cycle after a take, so a flag raised two cycles after a take is serviced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| vec_mode | input | 1 | 1: handler address depends on cause; 0: single entry point |
| id_undef | input | 1 | Decode-stage instruction has an undefined opcode |
| id_pc | input | 32 | PC of the decode-stage instruction |
| ex_ovf | input | 1 | Execute-stage instruction overflowed |
| ex_pc | input | 32 | PC of the execute-stage instruction |
| take | output | 1 | A trap is taken this cycle; fetch loads `redirect_pc` |
| kill_fetch | output | 1 | Zero the control values of the fetched instruction |
| kill_decode | output | 1 | Zero the control values of the decode-stage instruction |
| kill_execute | output | 1 | Zero the control values of the execute-stage instruction |
| redirect_pc | output | 32 | Handler address for the trap being taken |
| epc | output | 32 | Saved resume address (faulting PC + 4) |
| cause | output | 1 | Saved fault kind: 0 undefined opcode, 1 overflow |

## Verification
A wrong priority pick shows at the ports in the same cycle, because `kill_execute` and `redirect_pc` disagree with the flags that were driven. One edge later it shows again, because `epc` and `cause` hold the wrong source's PC and code. A state register stuck in ST_RUN shows in the cycle right after a take, when `take` rises a second time and `epc` is overwritten. A state register stuck in ST_SQUASH shows as a trap that is never taken. Errors in the capture registers, such as a wrong increment or a missing hold, appear on the first edge after the cycle in question.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int unsigned CAUSE_W = 1;

    localparam logic [CAUSE_W-1:0] CAUSE_UNDEF = 1'b0;
    localparam logic [CAUSE_W-1:0] CAUSE_OVF   = 1'b1;

    // Stage numbering, youngest first: a fault at stage f kills stages 0..f.
    localparam int unsigned STG_FETCH   = 0;
    localparam int unsigned STG_DECODE  = 1;
    localparam int unsigned STG_EXECUTE = 2;
    localparam int unsigned N_STG       = 3;

    typedef enum logic [0:0] {
        ST_RUN    = 1'b0,
        ST_SQUASH = 1'b1
    } exc_state_e;

endpackage

// File: rtl/exc_oldest_pick.sv
module exc_oldest_pick #(
    parameter int unsigned N_SRC = 2,
    parameter int unsigned AW    = 32,
    localparam int unsigned IW   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0]         req,
    input  logic [N_SRC-1:0][AW-1:0] src_pc,
    output logic                     hit,
    output logic [IW-1:0]            sel_idx,
    output logic [AW-1:0]            sel_pc
);

    // Index 0 is the oldest instruction; scanning downward lets it win.
    always_comb begin
        hit     = 1'b0;
        sel_idx = '0;
        sel_pc  = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                hit     = 1'b1;
                sel_idx = IW'(i);
                sel_pc  = src_pc[i];
            end
        end
    end

endmodule

// File: rtl/exc_handler_addr.sv
module exc_handler_addr #(
    parameter int unsigned XLEN          = 32,
    parameter int unsigned CW            = 1,
    parameter logic [31:0] SINGLE_ENTRY  = 32'h8000_0180,
    parameter logic [31:0] VEC_BASE      = 32'hC000_0000,
    parameter logic [31:0] VEC_STEP      = 32'h0000_0020
) (
    input  logic            vec_mode,
    input  logic [CW-1:0]   code,
    output logic [XLEN-1:0] addr
);

    logic [XLEN-1:0] vec_addr;

    always_comb begin
        vec_addr = XLEN'(VEC_BASE) + XLEN'(code) * XLEN'(VEC_STEP);
        addr     = vec_mode ? vec_addr : XLEN'(SINGLE_ENTRY);
    end

endmodule

// File: rtl/exc_capture_regs.sv
module exc_capture_regs #(
    parameter int unsigned XLEN        = 32,
    parameter int unsigned CW          = 1,
    parameter int unsigned INSTR_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic [XLEN-1:0] fault_pc,
    input  logic [CW-1:0]   fault_code,
    output logic [XLEN-1:0] epc_q,
    output logic [CW-1:0]   cause_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            epc_q   <= '0;
            cause_q <= '0;
        end else if (capture) begin
            epc_q   <= fault_pc + XLEN'(INSTR_BYTES);
            cause_q <= fault_code;
        end
    end

endmodule

// File: rtl/exc_flush_fsm.sv
module exc_flush_fsm
    import exc_pkg::*;
#(
    parameter int unsigned NS = N_STG,
    localparam int unsigned SW = $clog2(NS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit,
    input  logic [SW-1:0] fault_stage,
    output logic          take,
    output logic [NS-1:0] kill
);

    exc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (hit) begin
                    take    = 1'b1;
                    state_d = ST_SQUASH;
                end
            end
            ST_SQUASH: begin
                state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    for (genvar s = 0; s < NS; s++) begin : g_kill
        assign kill[s] = take && (SW'(s) <= fault_stage);
    end

endmodule

// File: rtl/exc_unit.sv
module exc_unit
    import exc_pkg::*;
#(
    parameter int unsigned XLEN         = 32,
    parameter logic [31:0] SINGLE_ENTRY = 32'h8000_0180,
    parameter logic [31:0] VEC_BASE     = 32'hC000_0000,
    parameter logic [31:0] VEC_STEP     = 32'h0000_0020
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            vec_mode,
    input  logic            id_undef,
    input  logic [XLEN-1:0] id_pc,
    input  logic            ex_ovf,
    input  logic [XLEN-1:0] ex_pc,
    output logic            take,
    output logic            kill_fetch,
    output logic            kill_decode,
    output logic            kill_execute,
    output logic [XLEN-1:0] redirect_pc,
    output logic [XLEN-1:0] epc,
    output logic [CAUSE_W-1:0] cause
);

    localparam int unsigned N_SRC = 2;
    localparam int unsigned IW    = $clog2(N_SRC);
    localparam int unsigned SW    = $clog2(N_STG);

    // Source 0 is older (execute), source 1 younger (decode).
    localparam logic [CAUSE_W-1:0] SRC_CODE  [N_SRC] = '{CAUSE_OVF, CAUSE_UNDEF};
    localparam logic [SW-1:0]      SRC_STAGE [N_SRC] = '{SW'(STG_EXECUTE), SW'(STG_DECODE)};

    logic [N_SRC-1:0]           src_req;
    logic [N_SRC-1:0][XLEN-1:0] src_pc;
    logic                       hit;
    logic [IW-1:0]              sel_idx;
    logic [XLEN-1:0]            sel_pc;
    logic [CAUSE_W-1:0]         sel_code;
    logic [SW-1:0]              sel_stage;
    logic [N_STG-1:0]           kill;

    assign src_req   = {id_undef, ex_ovf};
    assign src_pc    = {id_pc, ex_pc};
    assign sel_code  = SRC_CODE[sel_idx];
    assign sel_stage = SRC_STAGE[sel_idx];

    exc_oldest_pick #(
        .N_SRC (N_SRC),
        .AW    (XLEN)
    ) pick_i (
        .req     (src_req),
        .src_pc  (src_pc),
        .hit     (hit),
        .sel_idx (sel_idx),
        .sel_pc  (sel_pc)
    );

    exc_flush_fsm #(
        .NS (N_STG)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit         (hit),
        .fault_stage (sel_stage),
        .take        (take),
        .kill        (kill)
    );

    exc_handler_addr #(
        .XLEN         (XLEN),
        .CW           (CAUSE_W),
        .SINGLE_ENTRY (SINGLE_ENTRY),
        .VEC_BASE     (VEC_BASE),
        .VEC_STEP     (VEC_STEP)
    ) vec_i (
        .vec_mode (vec_mode),
        .code     (sel_code),
        .addr     (redirect_pc)
    );

    exc_capture_regs #(
        .XLEN        (XLEN),
        .CW          (CAUSE_W),
        .INSTR_BYTES (4)
    ) cap_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (take),
        .fault_pc   (sel_pc),
        .fault_code (sel_code),
        .epc_q      (epc),
        .cause_q    (cause)
    );

    assign kill_fetch   = kill[STG_FETCH];
    assign kill_decode  = kill[STG_DECODE];
    assign kill_execute = kill[STG_EXECUTE];

endmodule

// File: rtl/exc_unit_chk.sv
module exc_unit_chk #(
    parameter int unsigned XLEN         = 32,
    parameter logic [31:0] SINGLE_ENTRY = 32'h8000_0180,
    parameter logic [31:0] VEC_BASE     = 32'hC000_0000,
    parameter logic [31:0] VEC_STEP     = 32'h0000_0020
) (
    input logic            clk,
    input logic            rst_n,
    input logic            vec_mode,
    input logic            id_undef,
    input logic [XLEN-1:0] id_pc,
    input logic            ex_ovf,
    input logic [XLEN-1:0] ex_pc,
    input logic            take,
    input logic            kill_fetch,
    input logic            kill_decode,
    input logic            kill_execute,
    input logic [XLEN-1:0] redirect_pc,
    input logic [XLEN-1:0] epc,
    input logic [0:0]      cause
);

    p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !take |-> !kill_fetch && !kill_decode && !kill_execute);

    p_kill_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take && ex_ovf |-> kill_fetch && kill_decode && kill_execute);

    p_spare_older_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take && !ex_ovf |-> kill_fetch && kill_decode && !kill_execute);

    p_ovf_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take && ex_ovf && id_undef |=> cause == 1'b1);

    p_epc_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take && ex_ovf |=> epc == $past(ex_pc) + XLEN'(4));

    p_epc_undef_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take && !ex_ovf |=> epc == $past(id_pc) + XLEN'(4));

    p_cause_undef_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take && !ex_ovf |=> cause == 1'b0);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(epc) && $stable(cause));

    p_single_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take && !vec_mode |-> redirect_pc == XLEN'(SINGLE_ENTRY));

    p_vec_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take && vec_mode && ex_ovf |-> redirect_pc == XLEN'(VEC_BASE) + XLEN'(VEC_STEP));

    p_vec_undef_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take && vec_mode && !ex_ovf |-> redirect_pc == XLEN'(VEC_BASE));

    p_squash_r10: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take);

endmodule

bind exc_unit exc_unit_chk #(
    .XLEN         (XLEN),
    .SINGLE_ENTRY (SINGLE_ENTRY),
    .VEC_BASE     (VEC_BASE),
    .VEC_STEP     (VEC_STEP)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .vec_mode     (vec_mode),
    .id_undef     (id_undef),
    .id_pc        (id_pc),
    .ex_ovf       (ex_ovf),
    .ex_pc        (ex_pc),
    .take         (take),
    .kill_fetch   (kill_fetch),
    .kill_decode  (kill_decode),
    .kill_execute (kill_execute),
    .redirect_pc  (redirect_pc),
    .epc          (epc),
    .cause        (cause)
);

// File: tb/exc_unit_tb_top.sv
module exc_unit_tb_top;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vec_mode = 1'b0;
    logic        id_undef = 1'b0;
    logic [31:0] id_pc = '0;
    logic        ex_ovf = 1'b0;
    logic [31:0] ex_pc = '0;
    logic        take, kill_fetch, kill_decode, kill_execute;
    logic [31:0] redirect_pc, epc;
    logic [0:0]  cause;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] m_epc = '0;
    logic        m_cause = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    exc_unit dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .vec_mode     (vec_mode),
        .id_undef     (id_undef),
        .id_pc        (id_pc),
        .ex_ovf       (ex_ovf),
        .ex_pc        (ex_pc),
        .take         (take),
        .kill_fetch   (kill_fetch),
        .kill_decode  (kill_decode),
        .kill_execute (kill_execute),
        .redirect_pc  (redirect_pc),
        .epc          (epc),
        .cause        (cause)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic check_quiet(input string tag);
        check({tag, " take"}, 32'(take), 32'd0);
        check({tag, " kills"}, {29'd0, kill_execute, kill_decode, kill_fetch}, 32'd0);
    endtask

    task automatic run_case(input bit vm, input bit u, input bit o,
                            input logic [31:0] ipc, input logic [31:0] xpc);
        bit          exp_take;
        logic [2:0]  exp_kill;
        logic [31:0] exp_addr;
        bit          code;
        @(negedge clk);
        vec_mode = vm; id_undef = u; ex_ovf = o; id_pc = ipc; ex_pc = xpc;
        #(CLK_P/4);
        exp_take = u | o;
        code     = o;
        exp_kill = o ? 3'b111 : (u ? 3'b011 : 3'b000);
        exp_addr = vm ? (32'hC000_0000 + 32'(code) * 32'h20) : 32'h8000_0180;
        if (!exp_take) begin
            check_quiet("R1 no flag");
        end else begin
            check(o ? "R2 take" : "R3 take", 32'(take), 32'd1);
            check(o ? "R2 kills" : "R3 kills",
                  {29'd0, kill_execute, kill_decode, kill_fetch}, 32'(exp_kill));
            check(vm ? "R9 vector addr" : "R8 single entry", redirect_pc, exp_addr);
        end
        @(negedge clk);
        if (exp_take) begin
            m_epc   = (o ? xpc : ipc) + 32'd4;
            m_cause = code;
        end
        check(exp_take ? (o && u ? "R4 epc" : "R5 epc") : "R7 epc hold", epc, m_epc);
        check(exp_take ? (o && u ? "R4 cause" : "R6 cause") : "R7 cause hold",
              32'(cause), 32'(m_cause));
        if (exp_take) begin
            // squash cycle: raise both flags with other PCs; nothing may happen
            id_undef = 1'b1; ex_ovf = 1'b1; id_pc = ~ipc; ex_pc = ~xpc;
            #(CLK_P/4);
            check_quiet("R10 squash");
            @(negedge clk);
            check("R10 epc unchanged", epc, m_epc);
            check("R10 cause unchanged", 32'(cause), 32'(m_cause));
        end
        id_undef = 1'b0; ex_ovf = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check("R1 reset epc", epc, 32'd0);
        check("R1 reset cause", 32'(cause), 32'd0);
        check_quiet("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_quiet("R1 after release");

        for (int vm = 0; vm < 2; vm++) begin
            for (int combo = 0; combo < 4; combo++) begin
                for (int k = 0; k < 4; k++) begin
                    logic [31:0] xp;
                    xp = (k == 3) ? 32'hFFFF_FFFC : 32'h0000_1000 + 32'(k) * 32'h40 + 32'(combo) * 32'h400;
                    run_case(vm[0], combo[0], combo[1], xp + 32'd4, xp);
                end
            end
        end

        // R11: after a take, flag raised two cycles later is serviced
        @(negedge clk);
        vec_mode = 1'b0; id_undef = 1'b1; id_pc = 32'h0000_2220;
        #(CLK_P/4);
        check("R11 first take", 32'(take), 32'd1);
        @(negedge clk);
        id_undef = 1'b0;
        #(CLK_P/4);
        check("R11 squash quiet", 32'(take), 32'd0);
        @(negedge clk);
        ex_ovf = 1'b1; ex_pc = 32'h0000_3330;
        #(CLK_P/4);
        check("R11 second take", 32'(take), 32'd1);
        @(negedge clk);
        ex_ovf = 1'b0;
        check("R11 epc", epc, 32'h0000_3334);
        check("R11 cause", 32'(cause), 32'd1);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule